// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a bus-attached general-purpose I/O peripheral. It has one line per register bit, so the number of lines is set by `WIDTH`, which may be 8, 16, 32 or 64. Software reaches it through a plain register port. A write takes effect on the clock edge where `wr_en` is sampled. A read is requested with `rd_en`, and its data appears registered on `rdata` one cycle later. The pad side has a per-line output value (`pad_out`), a per-line output enable (`pad_oe`) and per-line input levels (`pad_in`). The input levels pass through a two-flop synchroniser before software can see them.

Each line has one output latch bit and one direction bit. Software changes the latch in three ways:
- as a whole word, through the level register;
- with atomic write-one-to-set accesses;
- with atomic write-one-to-clear accesses.

Direction is held in a single internal state. That state is visible through two complementary windows: one where a 1 means output, and one where a 1 means input. The two views therefore can never disagree.

Two parameters adapt the block to different software conventions. `CLR_PRESENT=0` removes the clear register, and the set register then acts as a plain latch load. `LINE0_MSB=1` mirrors the bit order, so line n sits at register bit `WIDTH-1-n`. The pad ports are always indexed by line.

Top module: `gpio_regfile`

## Requirements
- R1: While `rst` is high, and after its release, `pad_out`, `pad_oe` and `rdata` are all zero. Every line starts as an input with a latch of 0.
- R2: A read of address 0 (level) returns the pin level of each line. For an output line this is its latch bit. For an input line this is `pad_in`, delayed by the two-flop synchroniser; an input change is visible to a read request issued two or more cycles later.
- R3: With `CLR_PRESENT=1`, a write to address 1 (set) drives each line whose written bit is 1 to latch 1. Lines written with 0 keep their latch.
- R4: With `CLR_PRESENT=1`, a write to address 2 (clear) drives each line whose written bit is 1 to latch 0. Lines written with 0 keep their latch.
- R5: With `CLR_PRESENT=0`, a write to address 1 loads the latch with the written word, and a write to address 2 has no effect on any output.
- R6: A read of address 1 returns the output latch. A read of address 2 returns zero.
- R7: A write to address 3 (output direction) makes lines written 1 outputs and lines written 0 inputs. `pad_oe` follows on the next cycle, and `pad_out` always carries the latch.
- R8: A write to address 4 (input direction) makes lines written 1 inputs and lines written 0 outputs. Reads of addresses 3 and 4 always return bitwise complements.
- R9: With `LINE0_MSB=1`, line n maps to register bit `WIDTH-1-n` in every register, for both reads and writes. With `LINE0_MSB=0`, line n maps to bit n.
- R10: A write to address 0 loads the whole output latch with the written word.
- R11: `rdata` changes only on the cycle after `rd_en`. Addresses 5 to 7 read as zero, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | WIDTH | Write data, register bit order |
| rdata | output | WIDTH | Registered read data, register bit order |
| pad_in | input | WIDTH | Pad input levels, one per line |
| pad_out | output | WIDTH | Pad output values (latch), one per line |
| pad_oe | output | WIDTH | Pad output enables (1 = drive), one per line |

## Verification
The assertions assume that `addr` and `wdata` are stable and known whenever `wr_en` is high, and that `rd_en` and `wr_en` may arrive in any order. The bench changes the bus only at falling clock edges, and it holds each strobe high for exactly one cycle. `pad_in` is treated as asynchronous, so no property makes a claim about input lines beyond the synchroniser. The bench changes `pad_in` only between accesses, then waits three cycles before it reads the level register.

// File: rtl/gpio_regfile_pkg.sv
package gpio_regfile_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL = 3'd0,
    REG_SET   = 3'd1,
    REG_CLR   = 3'd2,
    REG_OE    = 3'd3,
    REG_IE    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_bit_order.sv
// Maps between line index and register bit position; self-inverse.
module gpio_bit_order #(
  parameter int WIDTH     = 8,
  parameter bit LINE0_MSB = 1'b0
) (
  input  logic [WIDTH-1:0] in_vec,
  output logic [WIDTH-1:0] out_vec
);
  generate
    if (LINE0_MSB) begin : g_mirror
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign out_vec[i] = in_vec[WIDTH-1-i];
      end
    end else begin : g_straight
      assign out_vec = in_vec;
    end
  endgenerate
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_line_state.sv
// Output latch and single direction state, both indexed by line.
module gpio_line_state
  import gpio_regfile_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit CLR_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wline,
  output logic [WIDTH-1:0] latch,
  output logic [WIDTH-1:0] dir
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
      dir   <= '0;
    end else if (we) begin
      case (sel)
        REG_LEVEL: latch <= wline;
        REG_SET:   latch <= CLR_PRESENT ? (latch | wline) : wline;
        REG_CLR:   if (CLR_PRESENT) latch <= latch & ~wline;
        REG_OE:    dir <= wline;
        REG_IE:    dir <= ~wline;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_regfile_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit LINE0_MSB   = 1'b0,
  parameter bit CLR_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] wr_line;
  logic [WIDTH-1:0] latch;
  logic [WIDTH-1:0] dir;
  logic [WIDTH-1:0] in_sync;
  logic [WIDTH-1:0] level;
  logic [WIDTH-1:0] rd_line;
  logic [WIDTH-1:0] rd_bits;

  assign sel = reg_sel_e'(addr);

  gpio_bit_order #(.WIDTH(WIDTH), .LINE0_MSB(LINE0_MSB)) u_wmap (
    .in_vec (wdata),
    .out_vec(wr_line)
  );

  gpio_line_state #(.WIDTH(WIDTH), .CLR_PRESENT(CLR_PRESENT)) u_state (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .sel  (sel),
    .wline(wr_line),
    .latch(latch),
    .dir  (dir)
  );

  gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pad_in),
    .q  (in_sync)
  );

  assign level = (dir & latch) | (~dir & in_sync);

  always_comb begin
    case (sel)
      REG_LEVEL: rd_line = level;
      REG_SET:   rd_line = latch;
      REG_OE:    rd_line = dir;
      REG_IE:    rd_line = ~dir;
      default:   rd_line = '0;
    endcase
  end

  gpio_bit_order #(.WIDTH(WIDTH), .LINE0_MSB(LINE0_MSB)) u_rmap (
    .in_vec (rd_line),
    .out_vec(rd_bits)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_bits;
  end

  assign pad_out = latch;
  assign pad_oe  = dir;
endmodule

// File: rtl/gpio_regfile_chk.sv
module gpio_regfile_chk
  import gpio_regfile_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit CLR_PRESENT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wdata,
  input logic [WIDTH-1:0]  rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0 && rdata == '0));

  // R3
  set_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_SET && CLR_PRESENT) |=> ((pad_out | $past(pad_out)) == pad_out));

  // R4
  clr_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_CLR && CLR_PRESENT) |=> ((pad_out & $past(pad_out)) == pad_out));

  // R5
  clr_absent_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_CLR && !CLR_PRESENT) |=> $stable(pad_out));

  // R7
  oe_count_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_OE) |=> ($countones(pad_oe) == $countones($past(wdata))));

  // R8
  ie_count_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_IE) |=> ($countones(pad_oe) == WIDTH - $countones($past(wdata))));

  // R11
  idle_pads_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || addr > REG_IE) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind gpio_regfile gpio_regfile_chk #(.WIDTH(WIDTH), .CLR_PRESENT(CLR_PRESENT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_regfile_test.sv
`timescale 1ns/1ps
module gpio_regfile_test;
  logic       clk = 1'b0;
  logic       rst, wr_en, rd_en;
  logic [2:0] addr;
  logic [7:0] wdata, pad_in;
  logic [7:0] rdata_a, out_a, oe_a;
  logic [7:0] rdata_b, out_b, oe_b;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] lat_a = '0, dir_a = '0;   // line indexed
  logic [7:0] lat_b = '0, dir_b = '0;   // line indexed

  always #10 clk = ~clk;

  // uut: straight order, clear register present
  gpio_regfile #(.WIDTH(8), .LINE0_MSB(1'b0), .CLR_PRESENT(1'b1)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_a), .pad_in(pad_in), .pad_out(out_a), .pad_oe(oe_a));

  // second instance: mirrored order, no clear register
  gpio_regfile #(.WIDTH(8), .LINE0_MSB(1'b1), .CLR_PRESENT(1'b0)) uut_m (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_b), .pad_in(pad_in), .pad_out(out_b), .pad_oe(oe_b));

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] exp_a(input logic [2:0] a);
    case (a)
      3'd0: return (dir_a & lat_a) | (~dir_a & pad_in);
      3'd1: return lat_a;
      3'd3: return dir_a;
      3'd4: return ~dir_a;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_b(input logic [2:0] a);
    case (a)
      3'd0: return rev8((dir_b & lat_b) | (~dir_b & pad_in));
      3'd1: return rev8(lat_b);
      3'd3: return rev8(dir_b);
      3'd4: return rev8(~dir_b);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: begin lat_a = d;          lat_b = rev8(d); end
      3'd1: begin lat_a = lat_a | d;  lat_b = rev8(d); end
      3'd2: begin lat_a = lat_a & ~d; end
      3'd3: begin dir_a = d;          dir_b = rev8(d); end
      3'd4: begin dir_a = ~d;         dir_b = ~rev8(d); end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " uut"}, rdata_a, exp_a(a));
    chk({tag, " uut_m"}, rdata_b, exp_b(a));
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] held_a, held_b;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pad_in = 8'h96;
    repeat (3) @(negedge clk);
    chk("R1 pad_out in reset", out_a | out_b, 8'h00);
    chk("R1 pad_oe in reset", oe_a | oe_b, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", rdata_a | rdata_b, 8'h00);
    chk("R1 pad_out after reset", out_a | out_b, 8'h00);
    rd(3'd3, "R1 all inputs");

    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v) ^ 8'hA5);
      chk("R10 level write uut", out_a, lat_a);
      chk("R10 R9 level write uut_m", out_b, lat_b);

      wr(3'd1, 8'(v));
      chk("R3 set write", out_a, lat_a);
      chk("R5 set loads", out_b, rev8(8'(v)));
      rd(3'd1, "R6 set readback");
      rd(3'd2, "R6 clear reads zero");

      wr(3'd2, 8'(v * 3));
      chk("R4 clear write", out_a, lat_a);
      chk("R5 clear ignored", out_b, lat_b);

      wr(3'd3, 8'(v));
      chk("R7 oe from dir_out", oe_a, 8'(v));
      chk("R9 oe mirrored", oe_b, rev8(8'(v)));
      rd(3'd4, "R8 dir_in complement");

      wr(3'd4, 8'(v) ^ 8'h3C);
      chk("R8 oe from dir_in", oe_a, ~(8'(v) ^ 8'h3C));
      chk("R8 R9 oe from dir_in mirrored", oe_b, ~rev8(8'(v) ^ 8'h3C));
      rd(3'd3, "R8 dir_out view");

      pad_in = 8'(v * 29 + 7);
      repeat (3) @(negedge clk);
      rd(3'd0, "R2 level read");

      if (v % 32 == 0) begin
        held_a = out_a; held_b = out_b;
        wr(3'(5 + (v / 32) % 3), 8'hFF);
        chk("R11 unmapped write out uut", out_a, held_a);
        chk("R11 unmapped write out uut_m", out_b, held_b);
        rd(3'(5 + (v / 32) % 3), "R11 unmapped read");
        rd(3'd1, "R11 pre-hold");
        held_a = rdata_a; held_b = rdata_b;
        wr(3'd0, 8'(~v));
        repeat (2) @(negedge clk);
        chk("R11 rdata hold uut", rdata_a, held_a);
        chk("R11 rdata hold uut_m", rdata_b, held_b);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule